// File: doc/BRIEF.md
# Serial Receive Word Buffer

This block takes a one-bit serial data line and its receive clock from outside the chip. It brings both into the system clock domain and builds words in a shift register. Each finished word goes into an eight-entry receive FIFO.

Software sees the oldest buffered word on a read port. Reading that port does not remove the word, because reads may be speculative. A word leaves the FIFO only when software writes an acknowledge with bit 0 set. A status set reports the number of buffered words, a flag for "count above threshold" and a sticky overrun flag. An interrupt output combines these status conditions.

Configuration inputs select:
- the bit order,
- the active receive-clock edge,
- halving of a receive clock that runs at twice the bit rate,
- the interrupt threshold.

They must be set while the receiver is disabled. A synchronous receiver reset returns every register to its power-up value.

Top module: `ser_rx_fifo`

## Requirements
- R1: Receive-clock edges are ignored while `rx_en_i` is low. Shifting starts with the first active edge seen after `rx_en_i` rises.
- R2: With `lsb_first_i`=0 the first received bit ends in bit 31 of the word. With `lsb_first_i`=1 it ends in bit 0.
- R3: With `fall_edge_i`=0 data is sampled on a 0→1 transition of `sclk_i`. With `fall_edge_i`=1 it is sampled on a 1→0 transition.
- R4: With `clk_div2_i`=1 only every second active edge samples data, starting with the first edge after enabling.
- R5: Every 32 sampled bits form one word that is written to the next free FIFO entry. Consecutive words follow with no gap bit.
- R6: A word that completes while the FIFO holds 8 words, with no acknowledge in the same cycle, is discarded and sets `overrun_o`. `overrun_o` stays set until a cycle with `ovr_clr_i`=1. A new overrun in that same cycle wins over the clear.
- R7: `avail_o` equals the number of buffered words. `thr_hit_o` is 1 exactly when `avail_o` is greater than `thresh_i`.
- R8: `irq_o` is 1 exactly when `irq_en_i`=1 and (`thr_hit_o`=1 or `overrun_o`=1).
- R9: `rx_data_o` shows the oldest buffered word. It is removed only by a cycle with `ack_wr_i`=1 and `ack_bit_i`=1 while the FIFO is not empty. Status reflects the removal on the next clock. An acknowledge with `ack_bit_i`=0 changes nothing.
- R10: If a word completes in the same cycle as an accepted acknowledge while the FIFO is full, the word is stored and no overrun is flagged.
- R11: A cycle with `rx_rst_i`=1 empties the FIFO, clears `overrun_o` and discards any partial word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_rst_i | input | 1 | Synchronous receiver reset |
| rx_en_i | input | 1 | Receiver enable |
| sclk_i | input | 1 | External receive clock (asynchronous) |
| sdata_i | input | 1 | External serial data (asynchronous) |
| lsb_first_i | input | 1 | 1: first bit is word bit 0; 0: first bit is word bit 31 |
| fall_edge_i | input | 1 | 1: sample on falling edge; 0: on rising edge |
| clk_div2_i | input | 1 | 1: use every second active edge |
| irq_en_i | input | 1 | Interrupt enable |
| thresh_i | input | 4 | Interrupt threshold (0 to 8) |
| ack_wr_i | input | 1 | Acknowledge register write strobe |
| ack_bit_i | input | 1 | Bit 0 of the acknowledge write data |
| ovr_clr_i | input | 1 | Write-1 clear of the overrun flag |
| rx_data_o | output | 32 | Oldest buffered word |
| avail_o | output | 4 | Number of buffered words |
| thr_hit_o | output | 1 | Buffered count above threshold |
| overrun_o | output | 1 | Sticky overrun flag |
| irq_o | output | 1 | Receive interrupt |

## Verification
A word that completes into a full FIFO can meet a software acknowledge in the same system cycle. The block must then both pop the head and store the new word, rather than flag an overrun.

The bench provokes this case on the last bit of a word. It counts the register stages from the serial-clock transition to the FIFO write, and places a single acknowledge pulse in exactly that write cycle. It then judges the outcome from three observations:
- the word count stays at 8,
- the overrun flag stays clear,
- the drained words come out in the expected order, ending with the word that arrived during the acknowledge.

// File: rtl/ser_rx_pkg.sv
package ser_rx_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_sel_e;
endpackage

// File: rtl/ser_rx_sync.sv
module ser_rx_sync
  import ser_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clr_i,
  input  logic      en_i,
  input  logic      sclk_i,
  input  logic      sdata_i,
  input  edge_sel_e edge_sel_i,
  input  logic      div2_i,
  output logic      bit_vld_o,
  output logic      bit_o
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] clk_q, dat_q;
  logic         clk_prev_q;
  logic         phase_q;
  logic         rise, fall, act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_q      <= '0;
      dat_q      <= '0;
      clk_prev_q <= 1'b0;
    end else begin
      clk_q      <= {clk_q[TOP-1:0], sclk_i};
      dat_q      <= {dat_q[TOP-1:0], sdata_i};
      clk_prev_q <= clk_q[TOP];
    end
  end

  assign rise = clk_q[TOP] & ~clk_prev_q;
  assign fall = ~clk_q[TOP] & clk_prev_q;
  assign act  = (edge_sel_i == EDGE_FALL) ? fall : rise;

  // divide-by-two phase: first edge after enable is used
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                phase_q <= 1'b0;
    else if (clr_i || !en_i)    phase_q <= 1'b0;
    else if (act && div2_i)     phase_q <= ~phase_q;
  end

  assign bit_vld_o = en_i & ~clr_i & act & (~div2_i | ~phase_q);
  assign bit_o     = dat_q[TOP];

  a_r4_div2_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && div2_i && act && !phase_q) |=> phase_q || !en_i || clr_i || !div2_i);
endmodule

// File: rtl/ser_rx_shift.sv
module ser_rx_shift #(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  input  logic              lsb_first_i,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int BC_W = $clog2(WORD_W);
  localparam logic [BC_W-1:0] LAST = BC_W'(WORD_W - 1);

  logic [WORD_W-1:0] sr_q, sr_nxt;
  logic [BC_W-1:0]   bcnt_q;

  assign sr_nxt = lsb_first_i ? {bit_i, sr_q[WORD_W-1:1]} : {sr_q[WORD_W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q       <= '0;
      bcnt_q     <= '0;
      word_vld_o <= 1'b0;
      word_o     <= '0;
    end else if (clr_i) begin
      sr_q       <= '0;
      bcnt_q     <= '0;
      word_vld_o <= 1'b0;
    end else begin
      word_vld_o <= 1'b0;
      if (bit_vld_i) begin
        sr_q <= sr_nxt;
        if (bcnt_q == LAST) begin
          bcnt_q     <= '0;
          word_o     <= sr_nxt;
          word_vld_o <= 1'b1;
        end else begin
          bcnt_q <= bcnt_q + 1'b1;
        end
      end
    end
  end

  a_r5_word_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> bcnt_q == '0);
  a_r5_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |=> !word_vld_o);
endmodule

// File: rtl/ser_rx_fifo_buf.sv
module ser_rx_fifo_buf #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               push_i,
  input  logic [WORD_W-1:0]  wdata_i,
  input  logic               pop_req_i,
  input  logic               ovr_clr_i,
  output logic [WORD_W-1:0]  rdata_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic               ovr_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              full, pop, accept, drop;

  assign full   = (cnt_q == CNT_FULL);
  assign pop    = pop_req_i && (cnt_q != '0);
  assign accept = push_i && (!full || pop);
  assign drop   = push_i && full && !pop;

  always_ff @(posedge clk_i) begin
    if (accept) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovr_o    <= 1'b0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovr_o    <= 1'b0;
    end else begin
      if (accept) wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
      if (pop)    rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({accept, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (drop)           ovr_o <= 1'b1;
      else if (ovr_clr_i) ovr_o <= 1'b0;
    end
  end

  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL);
  a_r6_drop_sets_ovr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_req_i && !clr_i) |=> ovr_o && cnt_q == CNT_FULL);
  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !ovr_clr_i && !clr_i) |=> ovr_o);
  a_r9_pop_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_req_i && cnt_q != '0 && !push_i && !clr_i) |=> cnt_q == $past(cnt_q) - 1'b1);
  a_r10_swap_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_req_i && full && !clr_i) |=> cnt_q == CNT_FULL && $stable(ovr_o));
  a_r11_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0 && !ovr_o);
endmodule

// File: rtl/ser_rx_fifo.sv
module ser_rx_fifo
  import ser_rx_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int DEPTH       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_rst_i,
  input  logic              rx_en_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              lsb_first_i,
  input  logic              fall_edge_i,
  input  logic              clk_div2_i,
  input  logic              irq_en_i,
  input  logic [CNT_W-1:0]  thresh_i,
  input  logic              ack_wr_i,
  input  logic              ack_bit_i,
  input  logic              ovr_clr_i,
  output logic [WORD_W-1:0] rx_data_o,
  output logic [CNT_W-1:0]  avail_o,
  output logic              thr_hit_o,
  output logic              overrun_o,
  output logic              irq_o
);
  logic              bit_vld, bit_val;
  logic              word_vld;
  logic [WORD_W-1:0] word;
  edge_sel_e         edge_sel;

  assign edge_sel = fall_edge_i ? EDGE_FALL : EDGE_RISE;

  ser_rx_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (rx_rst_i),
    .en_i       (rx_en_i),
    .sclk_i     (sclk_i),
    .sdata_i    (sdata_i),
    .edge_sel_i (edge_sel),
    .div2_i     (clk_div2_i),
    .bit_vld_o  (bit_vld),
    .bit_o      (bit_val)
  );

  ser_rx_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (rx_rst_i | ~rx_en_i),
    .bit_vld_i   (bit_vld),
    .bit_i       (bit_val),
    .lsb_first_i (lsb_first_i),
    .word_vld_o  (word_vld),
    .word_o      (word)
  );

  ser_rx_fifo_buf #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (rx_rst_i),
    .push_i    (word_vld),
    .wdata_i   (word),
    .pop_req_i (ack_wr_i & ack_bit_i),
    .ovr_clr_i (ovr_clr_i),
    .rdata_o   (rx_data_o),
    .count_o   (avail_o),
    .ovr_o     (overrun_o)
  );

  assign thr_hit_o = (avail_o > thresh_i);
  assign irq_o     = irq_en_i & (thr_hit_o | overrun_o);

  a_r1_idle_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en_i && !word_vld) |=> $stable(avail_o) || $past(ack_wr_i) || $past(rx_rst_i));
endmodule

// File: tb/ser_rx_fifo_tb.sv
module ser_rx_fifo_tb;
  localparam int WORD_W = 32;
  localparam int DEPTH  = 8;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int HALF   = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rx_rst_i = 1'b0, rx_en_i = 1'b0;
  logic sclk_i = 1'b0, sdata_i = 1'b0;
  logic lsb_first_i = 1'b0, fall_edge_i = 1'b0, clk_div2_i = 1'b0;
  logic irq_en_i = 1'b0;
  logic [CNT_W-1:0] thresh_i = CNT_W'(DEPTH);
  logic ack_wr_i = 1'b0, ack_bit_i = 1'b0, ovr_clr_i = 1'b0;
  logic [WORD_W-1:0] rx_data_o;
  logic [CNT_W-1:0]  avail_o;
  logic thr_hit_o, overrun_o, irq_o;

  int n_chk = 0, n_fail = 0, mdl_cnt = 0;
  logic [WORD_W-1:0] exp_q [$];
  bit done = 0;

  always #5 clk = ~clk;

  ser_rx_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_rst_i(rx_rst_i), .rx_en_i(rx_en_i),
    .sclk_i(sclk_i), .sdata_i(sdata_i), .lsb_first_i(lsb_first_i),
    .fall_edge_i(fall_edge_i), .clk_div2_i(clk_div2_i), .irq_en_i(irq_en_i),
    .thresh_i(thresh_i), .ack_wr_i(ack_wr_i), .ack_bit_i(ack_bit_i),
    .ovr_clr_i(ovr_clr_i), .rx_data_o(rx_data_o), .avail_o(avail_o),
    .thr_hit_o(thr_hit_o), .overrun_o(overrun_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: every accepted acknowledge pops the scoreboard head
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_ni && ack_wr_i && ack_bit_i && avail_o != '0) begin
        if (exp_q.size() == 0) check("R9 unexpected word", rx_data_o, 32'hx);
        else check("R9 head data", rx_data_o, exp_q.pop_front());
      end
    end
  end

  task automatic idle_lvl();
    sclk_i = fall_edge_i;
  endtask

  task automatic send_bit(input logic b, input bit ack_last);
    int reps = clk_div2_i ? 2 : 1;
    sdata_i = b;
    for (int r = 0; r < reps; r++) begin
      sclk_i = fall_edge_i;
      repeat (HALF) @(negedge clk);
      sclk_i = ~fall_edge_i;
      if (ack_last && r == reps - 1) begin
        // word reaches the FIFO write in the cycle after the third rising clock
        repeat (3) @(posedge clk);
        @(negedge clk); ack_wr_i = 1'b1; ack_bit_i = 1'b1;
        @(negedge clk); ack_wr_i = 1'b0; ack_bit_i = 1'b0;
        repeat (HALF - 2) @(negedge clk);
      end else begin
        repeat (HALF) @(negedge clk);
      end
    end
  endtask

  task automatic send_word(input logic [WORD_W-1:0] w, input bit ack_last);
    for (int i = 0; i < WORD_W; i++)
      send_bit(lsb_first_i ? w[i] : w[WORD_W-1-i], ack_last && i == WORD_W - 1);
    if (rx_en_i) begin
      if (mdl_cnt < DEPTH || ack_last) begin
        exp_q.push_back(w);
        if (!ack_last) mdl_cnt++;
      end
    end
  endtask

  task automatic do_ack(input logic b);
    @(negedge clk); ack_wr_i = 1'b1; ack_bit_i = b;
    @(negedge clk); ack_wr_i = 1'b0; ack_bit_i = 1'b0;
    if (b && mdl_cnt > 0) mdl_cnt--;
  endtask

  task automatic reconfig(input logic lsb, input logic fe, input logic d2);
    @(negedge clk); rx_en_i = 1'b0;
    lsb_first_i = lsb; fall_edge_i = fe; clk_div2_i = d2;
    idle_lvl();
    repeat (6) @(negedge clk);
    rx_en_i = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R7 reset avail", 32'(avail_o), 0);
    check("R6 reset overrun", 32'(overrun_o), 0);
    check("R8 reset irq", 32'(irq_o), 0);
    check("R7 reset thr", 32'(thr_hit_o), 0);

    // R1: disabled receiver ignores edges
    send_word(32'hDEAD_BEEF, 0);
    check("R1 disabled ignores", 32'(avail_o), 0);

    // R2/R5: MSB-first, rising edge, back to back
    reconfig(0, 0, 0);
    send_word(32'hA5C3_0F96, 0);
    send_word(32'h1234_5678, 0);
    check("R5 two words", 32'(avail_o), 2);
    do_ack(1'b0);
    check("R9 ack bit0 clear ignored", 32'(avail_o), 2);
    check("R9 head kept", rx_data_o, 32'hA5C3_0F96);
    do_ack(1'b1);
    check("R9 status after ack", 32'(avail_o), 1);
    do_ack(1'b1);
    check("R9 empty", 32'(avail_o), 0);

    // R2: LSB-first
    reconfig(1, 0, 0);
    send_word(32'h0000_00F1, 0);
    check("R2 lsb first", rx_data_o, 32'h0000_00F1);
    do_ack(1'b1);

    // R3: falling edge
    reconfig(0, 1, 0);
    send_word(32'h8C31_7E02, 0);
    check("R3 falling edge", rx_data_o, 32'h8C31_7E02);
    do_ack(1'b1);

    // R4: divide by two
    reconfig(0, 0, 1);
    send_word(32'h5AF0_3C81, 0);
    check("R4 div2 count", 32'(avail_o), 1);
    check("R4 div2 data", rx_data_o, 32'h5AF0_3C81);
    do_ack(1'b1);

    // R7/R8: threshold
    reconfig(0, 0, 0);
    thresh_i = 2; irq_en_i = 1'b1;
    send_word(32'h0000_0001, 0);
    send_word(32'h0000_0002, 0);
    check("R7 thr at equal", 32'(thr_hit_o), 0);
    check("R8 irq at equal", 32'(irq_o), 0);
    send_word(32'h0000_0003, 0);
    check("R7 thr above", 32'(thr_hit_o), 1);
    check("R8 irq above", 32'(irq_o), 1);
    do_ack(1'b1);
    check("R8 irq drop", 32'(irq_o), 0);
    do_ack(1'b1); do_ack(1'b1);
    check("R7 drained", 32'(avail_o), 0);

    // R6: overrun
    thresh_i = CNT_W'(DEPTH);
    for (int i = 0; i < DEPTH; i++) send_word(32'hC000_0000 + 32'(i), 0);
    check("R7 full count", 32'(avail_o), DEPTH);
    check("R8 no irq when full", 32'(irq_o), 0);
    send_word(32'hBAD0_BAD0, 0);
    check("R6 overrun set", 32'(overrun_o), 1);
    check("R6 count kept", 32'(avail_o), DEPTH);
    check("R8 irq on overrun", 32'(irq_o), 1);
    repeat (3) @(negedge clk);
    check("R6 sticky", 32'(overrun_o), 1);
    ovr_clr_i = 1'b1; @(negedge clk); ovr_clr_i = 1'b0;
    check("R6 cleared", 32'(overrun_o), 0);

    // R10: push and pop in the same cycle while full
    send_word(32'h7777_1010, 1);
    check("R10 count full", 32'(avail_o), DEPTH);
    check("R10 no overrun", 32'(overrun_o), 0);
    for (int i = 0; i < DEPTH; i++) do_ack(1'b1);
    check("R10 drained", 32'(avail_o), 0);
    check("R10 queue empty", 32'(exp_q.size()), 0);

    // R11: receiver reset
    send_word(32'h1111_2222, 0);
    send_word(32'h3333_4444, 0);
    @(negedge clk); rx_rst_i = 1'b1;
    @(negedge clk); rx_rst_i = 1'b0;
    exp_q.delete(); mdl_cnt = 0;
    check("R11 avail cleared", 32'(avail_o), 0);
    check("R11 overrun cleared", 32'(overrun_o), 0);
    send_word(32'h0F0F_A0A0, 0);
    check("R11 fresh word", rx_data_o, 32'h0F0F_A0A0);
    do_ack(1'b1);

    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule